// File: doc/BRIEF.md
# SDRAM Bank Activation Timing Tracker

This block stands between a memory request scheduler and the command bus of a four-bank synchronous DRAM. The scheduler offers one command per clock: open a row, read, write or close a row. The tracker answers in the same cycle with either a grant or a stall. A grant means the command may go onto the bus on the coming clock edge. For each bank the tracker keeps whether a row is open and which row that is. It also keeps the minimum command spacings that decide legality, each counted in whole clock cycles.

There are three timing limits, and each is a static input of at least 1:
- `t_rcd`: the minimum gap from opening a row to the first read or write of that bank.
- `t_rc`: the minimum gap between two row openings in the same bank.
- `t_rrd`: the minimum gap between row openings in any two banks.

To turn a limit given in nanoseconds into cycles, divide it by the clock period and round up to the next whole number. For example, 18 ns at an 8 ns period is 2.25, which becomes 3 cycles.

A stalled command must be held unchanged by the scheduler until it is granted. The tracker never reorders commands.

Top module: `sdram_act_tracker`

## Requirements
- R1: A synchronous active-high reset marks every bank closed and clears every timing window, so the first row opening after reset is granted in its first cycle.
- R2: `cmd_op` encodes open-row as 2'b00, read as 2'b01, write as 2'b10 and close-row as 2'b11. `cmd_bank` selects one of four banks. For open-row, `cmd_addr` carries the 12-bit row. A granted open-row sets that bank's bit in `bank_open` and stores the row at `bank_row[bank*12 +: 12]` on the granting edge.
- R3: A read or write to a bank whose `bank_open` bit is clear is stalled.
- R4: A read or write to an open bank whose row was opened on edge k is granted no earlier than edge k + `t_rcd`.
- R5: An open-row command to a bank that already has an open row is stalled until that bank is closed.
- R6: An open-row command to a bank last opened on edge k is granted no earlier than edge k + `t_rc`.
- R7: An open-row command to any bank is granted no earlier than edge k + `t_rrd`, where k is the edge of the most recent granted open-row to any bank.
- R8: A close-row command is always granted and clears the bank's `bank_open` bit. Closing a bank that is already closed changes no bank state.
- R9: `cmd_grant` is high only while `cmd_valid` is high. `cmd_stall` equals `cmd_valid` and not `cmd_grant`. At most one command is granted per clock.
- R10: A granted read or write changes neither `bank_open` nor `bank_row`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is offered this cycle |
| cmd_op | input | 2 | Command code (see R2) |
| cmd_bank | input | 2 | Target bank |
| cmd_addr | input | 12 | Row address for open-row; ignored for other commands |
| t_rcd | input | 8 | Open-to-access spacing in cycles |
| t_rc | input | 8 | Same-bank open-to-open spacing in cycles |
| t_rrd | input | 8 | Any-bank open-to-open spacing in cycles |
| cmd_grant | output | 1 | Offered command issues on the next edge |
| cmd_stall | output | 1 | Offered command must be held |
| bank_open | output | 4 | Per-bank open-row flags |
| bank_row | output | 48 | Open row of each bank, 12 bits per bank |

## Verification
The two functions that can fall in the same cycle are the end of a bank's own `t_rc` window and the end of the shared `t_rrd` window.

A second timing set makes the two windows equal (`t_rc` = `t_rrd` = 4). In that set the bench opens bank 0, closes it, and at once asks to open it again. The request must stall for exactly two cycles and be granted on the edge where both windows end together.

A behavioural reference model keeps the edge of the last open-row per bank and across all banks. It judges every cycle's grant, stall and bank state against that model, both during this case and during long runs of random commands.

// File: rtl/sdram_act_tracker.sv
module sdram_act_tracker #(
  parameter int BW = 2,
  parameter int RW = 12,
  parameter int CW = 8,
  localparam int NB = 1 << BW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [BW-1:0]     cmd_bank,
  input  logic [RW-1:0]     cmd_addr,
  input  logic [CW-1:0]     t_rcd,
  input  logic [CW-1:0]     t_rc,
  input  logic [CW-1:0]     t_rrd,
  output logic              cmd_grant,
  output logic              cmd_stall,
  output logic [NB-1:0]     bank_open,
  output logic [NB*RW-1:0]  bank_row
);

  localparam logic [1:0] OP_ACT = 2'b00;
  localparam logic [1:0] OP_RD  = 2'b01;
  localparam logic [1:0] OP_WR  = 2'b10;
  localparam logic [1:0] OP_PRE = 2'b11;

  logic [CW-1:0] rcd_cnt [NB];
  logic [CW-1:0] rc_cnt  [NB];
  logic [CW-1:0] rrd_cnt;
  logic          legal;

  wire is_act = cmd_op == OP_ACT;
  wire is_rw  = (cmd_op == OP_RD) || (cmd_op == OP_WR);
  wire is_pre = cmd_op == OP_PRE;

  function automatic logic [CW-1:0] reload(input logic [CW-1:0] t);
    return (t == '0) ? '0 : t - 1'b1;
  endfunction

  always_comb begin
    case (cmd_op)
      OP_ACT:  legal = !bank_open[cmd_bank] && rc_cnt[cmd_bank] == '0 && rrd_cnt == '0;
      OP_RD,
      OP_WR:   legal = bank_open[cmd_bank] && rcd_cnt[cmd_bank] == '0;
      default: legal = 1'b1;
    endcase
  end

  assign cmd_grant = cmd_valid && legal;
  assign cmd_stall = cmd_valid && !legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      rrd_cnt   <= '0;
      bank_open <= '0;
      bank_row  <= '0;
      for (int i = 0; i < NB; i++) begin
        rcd_cnt[i] <= '0;
        rc_cnt[i]  <= '0;
      end
    end else begin
      if (cmd_grant && is_act) rrd_cnt <= reload(t_rrd);
      else if (rrd_cnt != '0)  rrd_cnt <= rrd_cnt - 1'b1;
      for (int i = 0; i < NB; i++) begin
        if (cmd_grant && is_act && cmd_bank == BW'(i)) begin
          rcd_cnt[i]            <= reload(t_rcd);
          rc_cnt[i]             <= reload(t_rc);
          bank_open[i]          <= 1'b1;
          bank_row[i*RW +: RW]  <= cmd_addr;
        end else begin
          if (rcd_cnt[i] != '0) rcd_cnt[i] <= rcd_cnt[i] - 1'b1;
          if (rc_cnt[i] != '0)  rc_cnt[i]  <= rc_cnt[i] - 1'b1;
          if (cmd_grant && is_pre && cmd_bank == BW'(i)) bank_open[i] <= 1'b0;
        end
      end
    end
  end

  assert_reset_closed_R1: assert property (@(posedge clk)
    rst |=> bank_open == '0);

  assert_act_sets_open_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_grant && is_act) |=> bank_open[$past(cmd_bank)]);

  assert_access_needs_open_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_grant && is_rw) |-> bank_open[cmd_bank]);

  assert_rcd_gap_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_grant && is_act && t_rcd > 1) |=> !(cmd_grant && is_rw && cmd_bank == $past(cmd_bank)));

  assert_act_needs_closed_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_grant && is_act) |-> !bank_open[cmd_bank]);

  assert_rrd_gap_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_grant && is_act && t_rrd > 1) |=> !(cmd_grant && is_act));

  assert_pre_always_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && is_pre) |-> cmd_grant);

  assert_pre_closes_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_grant && is_pre) |=> !bank_open[$past(cmd_bank)]);

  assert_grant_stall_R9: assert property (@(posedge clk) disable iff (rst)
    !(cmd_grant && cmd_stall) && (cmd_grant -> cmd_valid));

  assert_rw_keeps_state_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_grant && is_rw) |=> $stable(bank_open) && $stable(bank_row));

endmodule

// File: tb/test_sdram_act_tracker.sv
module test_sdram_act_tracker;
  logic        clk = 0, rst = 1, cmd_valid = 0;
  logic [1:0]  cmd_op = 0, cmd_bank = 0;
  logic [11:0] cmd_addr = 0;
  logic [7:0]  t_rcd = 3, t_rc = 7, t_rrd = 2;
  logic        cmd_grant, cmd_stall;
  logic [3:0]  bank_open;
  logic [47:0] bank_row;

  always #4 clk = ~clk;

  sdram_act_tracker i_sdram_act_tracker (.*);

  int checks = 0, fails = 0, cyc = 0;
  int last_act[4];
  int last_any;
  bit mopen[4];
  logic [11:0] mrow[4];

  task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      last_act[i] = -1000; mopen[i] = 0; mrow[i] = '0;
    end
    last_any = -1000;
  endtask

  task automatic step(output bit g);
    bit e;
    string req;
    logic [47:0] rows;
    #1;
    e = 0;
    if (cmd_valid)
      case (cmd_op)
        2'b00: e = !mopen[cmd_bank] && (cyc - last_act[cmd_bank] >= t_rc) && (cyc - last_any >= t_rrd);
        2'b01, 2'b10: e = mopen[cmd_bank] && (cyc - last_act[cmd_bank] >= t_rcd);
        default: e = 1;
      endcase
    if (!rst) begin
      if (cmd_op == 2'b00) req = mopen[cmd_bank] ? "R5" : "R6/R7";
      else if (cmd_op == 2'b11) req = "R8";
      else req = mopen[cmd_bank] ? "R4" : "R3";
      if (!cmd_valid) req = "R9";
      check(cmd_grant == e, req, "grant", cmd_grant, e);
      check(cmd_stall == (cmd_valid && !e), "R9", "stall", cmd_stall, cmd_valid && !e);
      rows = '0;
      for (int i = 0; i < 4; i++) rows[i*12 +: 12] = mrow[i];
      req = (cmd_op == 2'b01 || cmd_op == 2'b10) ? "R10" : "R2";
      check(bank_open == {mopen[3], mopen[2], mopen[1], mopen[0]}, req, "bank_open",
            bank_open, {mopen[3], mopen[2], mopen[1], mopen[0]});
      for (int i = 0; i < 4; i++)
        if (mopen[i]) check(bank_row[i*12 +: 12] == mrow[i], req, "bank_row", bank_row[i*12 +: 12], mrow[i]);
    end
    g = e;
    @(posedge clk);
    if (rst) model_reset();
    else if (e) begin
      if (cmd_op == 2'b00) begin
        mopen[cmd_bank] = 1; mrow[cmd_bank] = cmd_addr;
        last_act[cmd_bank] = cyc; last_any = cyc;
      end else if (cmd_op == 2'b11) mopen[cmd_bank] = 0;
    end
    cyc++;
    @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] op, input int b, input int a, input int maxw,
                       output int waits, output bit got);
    bit g;
    cmd_valid = 1; cmd_op = op; cmd_bank = 2'(b); cmd_addr = 12'(a);
    waits = 0; got = 0;
    forever begin
      step(g);
      if (g) begin got = 1; break; end
      waits++;
      if (waits >= maxw) break;
    end
    cmd_valid = 0;
  endtask

  task automatic do_reset();
    bit g;
    rst = 1; cmd_valid = 0;
    repeat (3) step(g);
    rst = 0;
    #1;
    check(bank_open == 4'h0, "R1", "bank_open after reset", bank_open, 0);
    check(cmd_stall == 0 && cmd_grant == 0, "R1", "idle outputs", {cmd_grant, cmd_stall}, 0);
  endtask

  task automatic random_run(input int n);
    int w; bit got, g;
    for (int k = 0; k < n; k++) begin
      issue(2'($urandom_range(0, 3)), $urandom_range(0, 3), $urandom_range(0, 4095), 12, w, got);
      if ($urandom_range(0, 3) == 0) step(g);
    end
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL R9 watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    join_none
  end

  initial begin
    int w; bit got, g;
    model_reset();
    @(negedge clk);
    do_reset();

    issue(2'b00, 0, 12'h123, 12, w, got);
    check(got && w == 0, "R1", "first open waits", w, 0);
    #1 check(bank_row[11:0] == 12'h123 && bank_open[0], "R2", "row stored", bank_row[11:0], 12'h123);
    issue(2'b01, 0, 0, 12, w, got);
    check(got && w == 2, "R4", "read waits for t_rcd", w, 2);
    issue(2'b00, 1, 12'h0a5, 12, w, got);
    issue(2'b00, 2, 12'hfff, 12, w, got);
    check(got && w == 1, "R7", "cross-bank open waits", w, 1);
    issue(2'b00, 0, 12'h456, 5, w, got);
    check(!got && w == 5, "R5", "open on open bank stalls", got, 0);
    issue(2'b11, 0, 0, 12, w, got);
    check(got && w == 0, "R8", "close granted at once", w, 0);
    issue(2'b00, 0, 12'h456, 12, w, got);
    check(got, "R6", "reopen after t_rc", got, 1);
    issue(2'b11, 3, 0, 12, w, got);
    check(got && w == 0, "R8", "close on closed bank", w, 0);
    #1 check(bank_open == 4'b0111, "R8", "state unchanged", bank_open, 4'b0111);
    issue(2'b10, 3, 0, 6, w, got);
    check(!got, "R3", "write to closed bank stalls", got, 0);
    repeat (8) step(g);
    issue(2'b10, 2, 12'hbad, 12, w, got);
    check(got, "R10", "write granted", got, 1);
    #1 check(bank_row[35:24] == 12'hfff, "R10", "row kept after write", bank_row[35:24], 12'hfff);
    random_run(300);

    t_rcd = 2; t_rc = 4; t_rrd = 4;
    do_reset();
    issue(2'b00, 0, 12'h111, 12, w, got);
    issue(2'b11, 0, 0, 12, w, got);
    issue(2'b00, 0, 12'h222, 12, w, got);
    check(got && w == 2, "R6/R7", "coinciding windows", w, 2);
    random_run(300);

    t_rcd = 1; t_rc = 1; t_rrd = 1;
    do_reset();
    issue(2'b00, 1, 12'h0f0, 12, w, got);
    issue(2'b01, 1, 0, 12, w, got);
    check(got && w == 0, "R4", "access with t_rcd of one", w, 0);
    random_run(200);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule